// File: doc/BRIEF.md
# Phase Detector Sample Ratio Counter

This block tallies the output of a phase detector over a gated measurement window. Each clock cycle supplies one sampled bit. While the window is open, a low sample adds one to a low tally and a high sample adds one to a high tally. A calibrator clears the tallies and opens the window. After about two milliseconds it closes the window and reads both tallies. It then computes low / (low + high). A ratio crossing one half marks the position of the data edge.

The tallies are frozen while the window is closed, so they can be read at leisure. If either tally wraps past its largest value, a sticky overrun flag rises and both tallies stop counting. The calibrator must then discard that measurement. A clear strobe or the block reset re-arms the block. The tally width is a parameter. The default of 20 bits covers a 2 ms window at clock rates up to about 500 MHz.

Top module: `phase_ratio_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, both tallies and `overrun` read 0 after that edge.
- R2: When `meas_clr` is high at a rising clock edge, both tallies and `overrun` read 0 after that edge, even if `meas_en` is also high.
- R3: At an edge where `meas_en` is low and `meas_clr` is low, neither tally changes.
- R4: At an edge where `meas_en` is high, `overrun` is 0 and `meas_clr` is low:
  - if `pd_sample` is 1, `hi_count` rises by exactly 1 and `lo_count` does not change;
  - if `pd_sample` is 0, `lo_count` rises by exactly 1 and `hi_count` does not change.
- R5: When the tally selected under R4 holds its largest value (all ones), the increment wraps it to 0 and sets `overrun` to 1 after the same edge.
- R6: Once `overrun` is 1, it stays 1, and both tallies hold their values, until a clear strobe or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_clr | input | 1 | Clear strobe for both tallies and the overrun flag |
| meas_en | input | 1 | Window gate; counting happens only while it is high |
| pd_sample | input | 1 | Phase detector sample for this cycle |
| hi_count | output | CNT_W | Number of high samples in the window |
| lo_count | output | CNT_W | Number of low samples in the window |
| overrun | output | 1 | Sticky flag: a tally wrapped, so the measurement is invalid |

## Verification
The bench drives the following sample patterns, with a reduced 4-bit width so that wraps come quickly:
- Constant-high and constant-low runs show that each sample value steers only its own tally.
- Alternating and irregular patterns show that the two tallies split the enabled cycles exactly.
- Windows with gaps in the enable confirm that the tallies freeze while the window is closed.
- A clear strobe during an open window checks that clearing takes priority over counting.
- Long high and long low runs drive each tally through its wrap. They confirm the overrun flag, and that the tallies stay frozen while the flag is set.

// File: rtl/phase_ratio_pkg.sv
package phase_ratio_pkg;
  // Tally lane indices
  typedef enum logic {LANE_LO = 1'b0, LANE_HI = 1'b1} lane_e;
  localparam int NUM_LANES = 2;
endpackage

// File: rtl/sample_tally.sv
module sample_tally #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Wrap happens on the increment out of the all-ones value
  assign wrap = inc && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  a_r3_hold_without_inc: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt));
  a_r2_tally_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/overrun_latch.sv
module overrun_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || clr) flag <= 1'b0;
    else if (set)   flag <= 1'b1;
  end

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/phase_ratio_counter.sv
module phase_ratio_counter
  import phase_ratio_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_clr,
  input  logic             meas_en,
  input  logic             pd_sample,
  output logic [CNT_W-1:0] hi_count,
  output logic [CNT_W-1:0] lo_count,
  output logic             overrun
);
  logic             count_go;
  logic [NUM_LANES-1:0] lane_inc;
  logic [NUM_LANES-1:0] lane_wrap;
  logic [CNT_W-1:0] lane_cnt [NUM_LANES];

  // Counting is gated by the window, and halted once the measurement is invalid
  assign count_go = meas_en && !overrun && !meas_clr;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    // Each lane is selected by the sample value equal to its index
    assign lane_inc[g] = count_go && (pd_sample == g[0]);

    sample_tally #(.CNT_W(CNT_W)) i_tally (
      .clk  (clk),
      .rst  (rst),
      .clr  (meas_clr),
      .inc  (lane_inc[g]),
      .cnt  (lane_cnt[g]),
      .wrap (lane_wrap[g])
    );
  end

  overrun_latch i_ovr (
    .clk  (clk),
    .rst  (rst),
    .clr  (meas_clr),
    .set  (|lane_wrap),
    .flag (overrun)
  );

  assign hi_count = lane_cnt[LANE_HI];
  assign lo_count = lane_cnt[LANE_LO];

  a_r4_hi_only: assert property (@(posedge clk) disable iff (rst)
    (meas_en && !overrun && !meas_clr && pd_sample) |=> $stable(lo_count));
  a_r4_lo_only: assert property (@(posedge clk) disable iff (rst)
    (meas_en && !overrun && !meas_clr && !pd_sample) |=> $stable(hi_count));
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (overrun && !meas_clr) |=> ($stable(hi_count) && $stable(lo_count)));
  a_r2_clear_all: assert property (@(posedge clk) disable iff (rst)
    meas_clr |=> (hi_count == '0 && lo_count == '0 && !overrun));
  a_r5_wrap_flags: assert property (@(posedge clk) disable iff (rst)
    (count_go && pd_sample && hi_count == '1) |=> (overrun && hi_count == '0));
endmodule

// File: tb/test_phase_ratio_counter.sv
module test_phase_ratio_counter;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, en = 1'b0, smp = 1'b0;
  logic [W-1:0] hi, lo;
  logic ovr;

  always #2.5 clk = ~clk;

  phase_ratio_counter #(.CNT_W(W)) i_phase_ratio_counter (
    .clk(clk), .rst(rst), .meas_clr(clr), .meas_en(en), .pd_sample(smp),
    .hi_count(hi), .lo_count(lo), .overrun(ovr)
  );

  int checks = 0, errors = 0;
  int m_hi = 0, m_lo = 0, m_ov = 0;
  string tag = "R1";

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_hi = 0; m_lo = 0; m_ov = 0; tag = "R1";
    end else if (clr) begin
      m_hi = 0; m_lo = 0; m_ov = 0; tag = "R2";
    end else if (!en) begin
      tag = (m_ov != 0) ? "R6" : "R3";
    end else if (m_ov != 0) begin
      tag = "R6";
    end else if (smp) begin
      if (m_hi == MAX) begin m_hi = 0; m_ov = 1; tag = "R5"; end
      else begin m_hi++; tag = "R4"; end
    end else begin
      if (m_lo == MAX) begin m_lo = 0; m_ov = 1; tag = "R5"; end
      else begin m_lo++; tag = "R4"; end
    end
  end

  task automatic compare();
    checks++;
    if (hi !== W'(m_hi) || lo !== W'(m_lo) || ovr !== m_ov[0]) begin
      errors++;
      $display("FAIL %s: hi=%0d lo=%0d ovr=%0b expected hi=%0d lo=%0d ovr=%0d",
               tag, hi, lo, ovr, m_hi, m_lo, m_ov);
    end
  endtask

  // Compare after the previous edge, then set inputs for the next one
  task automatic step(input logic r, input logic c, input logic e, input logic s);
    @(negedge clk);
    compare();
    rst = r; clr = c; en = e; smp = s;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0);
    step(1, 0, 1, 1);
    step(0, 1, 0, 0);                                   // R1 reset state check
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1);       // R4 high run
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0);       // R4 low run
    for (int i = 0; i < 6; i++) step(0, 0, 0, i[0]);    // R3 window closed
    for (int i = 0; i < 6; i++) step(0, 0, 1, i[0]);    // R4 alternating
    step(0, 1, 1, 1);                                   // R2 clear beats enable
    for (int i = 0; i < 9; i++) step(0, 0, i % 3 != 0, (i * 5) % 7 > 2);
    step(0, 1, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 1);      // R5 high wrap, R6 hold
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0);       // R6 no counting
    step(0, 1, 0, 0);                                   // R2 clears overrun
    for (int i = 0; i < 18; i++) step(0, 0, 1, 0);      // R5 low wrap
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);       // R6 closed and flagged
    step(1, 0, 1, 1);                                   // R1 reset clears flag
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule